// File: doc/BRIEF.md
# USB Burst Write Qualifier with Clock-Crossing FIFO

This block takes 16-bit words from a USB interface chip whose write strobe stays high for one cycle more than the data it actually delivers. A burst counter in the USB clock domain follows the strobe. The counter has one spare top bit. During the surplus strobe cycle at the end of every 256-word burst, that top bit is set, and the write enable is blocked for that cycle.

Qualified words enter a dual-clock FIFO. The FIFO moves them from the USB clock domain into a signal-processing clock domain, where a read port hands them out one per read request. The write side reports full and a sticky overrun indication. The read side reports empty.

Top module: `usb_burst_fifo`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `rd_empty` is 1, `wr_full` is 0, `wr_overrun` is 0, `rd_data` is 0 and the burst counter is 0.
- R2: The burst counter advances by one on every `wr_clk` cycle in which `wr_strobe` is high, and holds its value on cycles in which `wr_strobe` is low. A strobe cycle taken while the count is below 256 writes that cycle's `wr_data` as one word.
- R3: A strobe cycle taken while the count equals 256 writes nothing, and the counter returns to 0. As a result, 257 strobe cycles, with or without idle gaps between them, deliver exactly 256 words.
- R4: Words leave the read port in the order in which they were written, and no word is lost or repeated across the two clock domains.
- R5: When `rd_en` is sampled high on a `rd_clk` edge while `rd_empty` is 0, the next word appears on `rd_data` at that same edge, so it is valid one read cycle after the request.
- R6: A read request while `rd_empty` is 1 is ignored: `rd_data` holds its value and the next stored word is not skipped.
- R7: `wr_full` is 1 once 512 words are stored and not yet read. A qualified write while `wr_full` is 1 is discarded.
- R8: `wr_overrun` becomes 1 on the cycle after a qualified write meets `wr_full`. It then stays at 1, even after the FIFO drains, until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | USB-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_strobe | input | 1 | Write strobe from the USB chip, one word per high cycle |
| wr_data | input | 16 | Word offered with the strobe |
| wr_full | output | 1 | FIFO holds its full capacity (write-clock view) |
| wr_overrun | output | 1 | Sticky: a qualified word was dropped because the FIFO was full |
| rd_clk | input | 1 | Signal-processing clock |
| rd_en | input | 1 | Read request |
| rd_data | output | 16 | Registered read word |
| rd_empty | output | 1 | No word available (read-clock view) |

## Verification
A burst counter that is off by one, or that keeps counting while the strobe is low, shows up at the read port. After a single burst, one stray trailing word appears or one real word is missing, so the damage is visible as soon as that burst is drained. A wrong pointer or a wrong Gray-code step shows up as out-of-order or repeated `rd_data`, or as an empty flag that never clears within a few read cycles. A wrong full comparison shows up as `wr_full` failing to rise after two back-to-back bursts. A wrong overrun register shows up as `wr_overrun` missing on the very next write cycle, or as `wr_overrun` clearing once the FIFO drains.

// File: rtl/usb_bq_pkg.sv
`timescale 1ns/1ps
package usb_bq_pkg;

  // Binary to reflected Gray code.
  function automatic logic [31:0] gray_of(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Next burst count: wraps to zero after the tail (surplus strobe) value.
  function automatic logic [31:0] burst_step(input logic [31:0] cnt,
                                             input logic [31:0] tail);
    return (cnt >= tail) ? 32'd0 : cnt + 32'd1;
  endfunction

  // Gray pointer of the writer equals the reader's pointer shifted by one lap.
  function automatic logic [31:0] lap_ahead(input logic [31:0] g, input int unsigned pw);
    logic [31:0] flip;
    flip = 32'd3 << (pw - 2);
    return g ^ flip;
  endfunction

endpackage

// File: rtl/usb_burst_qual.sv
`timescale 1ns/1ps
module usb_burst_qual import usb_bq_pkg::*; #(
  parameter int BURST_LEN = 256,
  localparam int CNT_W = $clog2(BURST_LEN) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  output logic [CNT_W-1:0] cnt,
  output logic             qualified
);

  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt   = CNT_W'(burst_step(32'(cnt), 32'(BURST_LEN)));
  assign qualified = strobe & ~cnt[CNT_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (strobe) cnt <= cnt_nxt;
  end

endmodule

// File: rtl/usb_ptr_sync.sv
`timescale 1ns/1ps
module usb_ptr_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= din;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/usb_fifo_ram.sv
`timescale 1ns/1ps
module usb_fifo_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/usb_burst_fifo.sv
`timescale 1ns/1ps
module usb_burst_fifo import usb_bq_pkg::*; #(
  parameter int DATA_W      = 16,
  parameter int BURST_LEN   = 256,
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic              wr_overrun,
  input  logic              rd_clk,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);

  localparam int CNT_W = $clog2(BURST_LEN) + 1;
  localparam int PW    = ADDR_W + 1;

  // Named internal events, observed by the bound checker.
  logic [CNT_W-1:0] burst_cnt;
  logic             wr_req;
  logic             wr_push;
  logic             rd_pop;

  logic [PW-1:0] wptr_bin, wptr_gray, wptr_bin_nxt;
  logic [PW-1:0] rptr_bin, rptr_gray, rptr_bin_nxt;
  logic [PW-1:0] rgray_in_wr, wgray_in_rd;

  usb_burst_qual #(.BURST_LEN(BURST_LEN)) u_qual (
    .clk       (wr_clk),
    .rst_n     (rst_n),
    .strobe    (wr_strobe),
    .cnt       (burst_cnt),
    .qualified (wr_req)
  );

  // ---------------- write domain ----------------
  assign wr_full      = (wptr_gray == PW'(lap_ahead(32'(rgray_in_wr), PW)));
  assign wr_push      = wr_req & ~wr_full;
  assign wptr_bin_nxt = wptr_bin + PW'(1);

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
    end else if (wr_push) begin
      wptr_bin  <= wptr_bin_nxt;
      wptr_gray <= PW'(gray_of(32'(wptr_bin_nxt)));
    end
  end

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n)                  wr_overrun <= 1'b0;
    else if (wr_req && wr_full)  wr_overrun <= 1'b1;
  end

  usb_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
    .clk   (wr_clk),
    .rst_n (rst_n),
    .din   (rptr_gray),
    .dout  (rgray_in_wr)
  );

  // ---------------- read domain ----------------
  assign rd_empty     = (rptr_gray == wgray_in_rd);
  assign rd_pop       = rd_en & ~rd_empty;
  assign rptr_bin_nxt = rptr_bin + PW'(1);

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
    end else if (rd_pop) begin
      rptr_bin  <= rptr_bin_nxt;
      rptr_gray <= PW'(gray_of(32'(rptr_bin_nxt)));
    end
  end

  usb_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
    .clk   (rd_clk),
    .rst_n (rst_n),
    .din   (wptr_gray),
    .dout  (wgray_in_rd)
  );

  usb_fifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wr_clk (wr_clk),
    .we     (wr_push),
    .waddr  (wptr_bin[ADDR_W-1:0]),
    .wdata  (wr_data),
    .rd_clk (rd_clk),
    .rst_n  (rst_n),
    .re     (rd_pop),
    .raddr  (rptr_bin[ADDR_W-1:0]),
    .rdata  (rd_data)
  );

endmodule

// File: rtl/usb_burst_fifo_chk.sv
`timescale 1ns/1ps
module usb_burst_fifo_chk #(
  parameter int BURST_LEN = 256,
  parameter int CNT_W     = 9,
  parameter int PW        = 10
) (
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             rst_n,
  input logic             wr_strobe,
  input logic             wr_req,
  input logic             wr_full,
  input logic             wr_overrun,
  input logic [CNT_W-1:0] burst_cnt,
  input logic [PW-1:0]    wptr_bin,
  input logic [PW-1:0]    wptr_gray,
  input logic             rd_empty,
  input logic [PW-1:0]    rptr_bin
);

  localparam logic [CNT_W-1:0] TAIL = CNT_W'(BURST_LEN);

  AST_CNT_LIMIT: assert property (@(posedge wr_clk) disable iff (!rst_n)
    burst_cnt <= TAIL);                                              // R2
  AST_CNT_HOLD: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_strobe |=> $stable(burst_cnt));                              // R2
  AST_TAIL_NO_REQ: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_strobe && burst_cnt == TAIL) |-> !wr_req);                   // R3
  AST_TAIL_WRAP: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_strobe && burst_cnt == TAIL) |=> burst_cnt == '0);           // R3
  AST_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);                  // R4
  AST_FULL_BLOCK: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_full && wr_req) |=> $stable(wptr_bin));                      // R7
  AST_OVR_SET: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_full && wr_req) |=> wr_overrun);                             // R8
  AST_OVR_STICKY: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_overrun |=> wr_overrun);                                      // R8
  AST_EMPTY_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_empty |=> $stable(rptr_bin));                                 // R6

endmodule

bind usb_burst_fifo usb_burst_fifo_chk #(
  .BURST_LEN(BURST_LEN), .CNT_W(CNT_W), .PW(PW)
) u_chk (
  .wr_clk     (wr_clk),
  .rd_clk     (rd_clk),
  .rst_n      (rst_n),
  .wr_strobe  (wr_strobe),
  .wr_req     (wr_req),
  .wr_full    (wr_full),
  .wr_overrun (wr_overrun),
  .burst_cnt  (burst_cnt),
  .wptr_bin   (wptr_bin),
  .wptr_gray  (wptr_gray),
  .rd_empty   (rd_empty),
  .rptr_bin   (rptr_bin)
);

// File: tb/usb_burst_fifo_bench.sv
`timescale 1ns/1ps
module usb_burst_fifo_bench;

  localparam int BURST = 256;
  localparam int DEPTH = 512;

  logic        wr_clk = 1'b0;
  logic        rd_clk = 1'b0;
  logic        rst_n  = 1'b0;
  logic        wr_strobe = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_full, wr_overrun;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        rd_empty;

  always #2.5 wr_clk = ~wr_clk;   // 200 MHz
  always #3.5 rd_clk = ~rd_clk;

  usb_burst_fifo u_usb_burst_fifo (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_data(wr_data),
    .wr_full(wr_full), .wr_overrun(wr_overrun),
    .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model of the write side.
  int          mcnt   = 0;
  int          stored = 0;
  logic [15:0] exp_q[$];

  function automatic bit model_takes(int cnt);
    return cnt < BURST;
  endfunction

  function automatic int model_next(int cnt);
    return (cnt == BURST) ? 0 : cnt + 1;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic wr_cycle(input bit s, input logic [15:0] d);
    @(negedge wr_clk);
    wr_strobe = s;
    wr_data   = d;
    if (s) begin
      if (model_takes(mcnt)) begin
        if (stored < DEPTH) begin
          exp_q.push_back(d);
          stored++;
        end
      end
      mcnt = model_next(mcnt);
    end
  endtask

  // 257 strobe cycles; the last is the surplus one.
  task automatic send_burst(input bit gaps, input int n_strobes);
    for (int i = 0; i < n_strobes; i++) begin
      if (gaps && $urandom_range(0, 3) == 0)
        repeat ($urandom_range(1, 4)) wr_cycle(1'b0, 16'($urandom));
      wr_cycle(1'b1, 16'($urandom));
    end
    wr_cycle(1'b0, 16'h0);
  endtask

  task automatic drain(input string req, input int expect_words);
    int got = 0;
    int wait_n;
    while (exp_q.size() > 0) begin
      wait_n = 0;
      @(negedge rd_clk);
      while (rd_empty && wait_n < 20) begin
        @(negedge rd_clk);
        wait_n++;
      end
      if (rd_empty) begin
        check(1'b0, "R4 empty stuck", 32'(rd_empty), 32'd0);
        break;
      end
      rd_en = 1'b1;
      @(negedge rd_clk);
      rd_en = 1'b0;
      begin
        logic [15:0] e;
        e = exp_q.pop_front();
        stored--;
        got++;
        check(rd_data == e, $sformatf("R4/R5 %s word %0d", req, got), 32'(rd_data), 32'(e));
      end
    end
    repeat (8) @(negedge rd_clk);
    check(got == expect_words, $sformatf("R3 %s word count", req), 32'(got), 32'(expect_words));
    check(rd_empty == 1'b1, $sformatf("R3 %s no stray word", req), 32'(rd_empty), 32'd1);
  endtask

  task automatic do_reset();
    rd_en = 1'b0;
    wr_strobe = 1'b0;
    rst_n = 1'b0;
    mcnt = 0;
    stored = 0;
    exp_q.delete();
    repeat (4) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge rd_clk);
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [15:0] hold;
    void'($urandom(32'h5EED_0042));

    // R1: reset state
    repeat (3) @(negedge wr_clk);
    check(rd_empty == 1'b1, "R1 empty in reset", 32'(rd_empty), 32'd1);
    check(wr_full == 1'b0, "R1 full in reset", 32'(wr_full), 32'd0);
    do_reset();
    check(rd_empty == 1'b1, "R1 empty after reset", 32'(rd_empty), 32'd1);
    check(wr_full == 1'b0, "R1 full after reset", 32'(wr_full), 32'd0);
    check(wr_overrun == 1'b0, "R1 overrun after reset", 32'(wr_overrun), 32'd0);
    check(rd_data == 16'h0, "R1 rd_data after reset", 32'(rd_data), 32'd0);

    // R6: reads while empty are ignored
    hold = rd_data;
    @(negedge rd_clk);
    rd_en = 1'b1;
    repeat (3) @(negedge rd_clk);
    rd_en = 1'b0;
    check(rd_data == hold, "R6 rd_data held on empty read", 32'(rd_data), 32'(hold));
    check(rd_empty == 1'b1, "R6 still empty", 32'(rd_empty), 32'd1);

    // R2/R3: continuous burst, first word must be the first written (R6 no skip)
    send_burst(1'b0, BURST + 1);
    drain("continuous", BURST);

    // R2/R3: bursts with idle gaps inside
    for (int b = 0; b < 2; b++) begin
      send_burst(1'b1, BURST + 1);
      drain($sformatf("gapped%0d", b), BURST);
    end

    // R7: two back-to-back bursts fill the FIFO
    send_burst(1'b0, 2 * (BURST + 1));
    repeat (4) @(negedge wr_clk);
    check(wr_full == 1'b1, "R7 full after 512 words", 32'(wr_full), 32'd1);
    check(wr_overrun == 1'b0, "R8 no overrun yet", 32'(wr_overrun), 32'd0);

    // R8: one more qualified word meets a full FIFO
    wr_cycle(1'b1, 16'hBEEF);
    wr_cycle(1'b0, 16'h0);
    check(wr_overrun == 1'b1, "R8 overrun set", 32'(wr_overrun), 32'd1);
    check(wr_full == 1'b1, "R7 still full", 32'(wr_full), 32'd1);
    drain("full", DEPTH);
    repeat (4) @(negedge wr_clk);
    check(wr_overrun == 1'b1, "R8 overrun sticky after drain", 32'(wr_overrun), 32'd1);
    check(wr_full == 1'b0, "R7 full cleared after drain", 32'(wr_full), 32'd0);

    // R8/R1: reset clears overrun; counter restarts at zero
    do_reset();
    check(wr_overrun == 1'b0, "R8 overrun cleared by reset", 32'(wr_overrun), 32'd0);
    send_burst(1'b1, BURST + 1);
    drain("after reset", BURST);

    report();
  end

endmodule